// File: doc/BRIEF.md
# One-Shot Programmable Down-Counter Timer

This block is an 8-bit timer that counts down once and then stops. Software places a start value into the counter. It can write the whole byte at once, or it can write the low half or the high half on its own. A separate start strobe arms the count. While armed, the counter drops by one on each pulse of the tick enable picked by a rate-select input. One tick input is the slow prescaled rate and the other is the fast prescaled rate. Both are produced outside this block.

The count moves from zero to all-ones on the next selected tick. On that tick the timer disarms itself, parks the counter at all-ones and raises its event flag. The flag then produces an interrupt request and a hold-release request, each gated by its own enable input. The flag stays set until the next accepted start.

Any write to the counter aborts a count in progress and disarms the timer, so software must strobe start again.

Top module: `oneshot_dtimer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `count` is 0 and `running` and `evt_flag` are 0.
- R2: A byte write (`wr_byte`=1) loads `wr_data[7:0]` into the counter, and `count` shows it one cycle later. A byte write takes precedence over any nibble write in the same cycle.
- R3: A low-nibble write (`wr_lo`=1) replaces `count[3:0]` with `wr_data[3:0]`. A high-nibble write (`wr_hi`=1) replaces `count[7:4]` with `wr_data[7:4]`. The other half keeps its value, and both writes may occur in the same cycle.
- R4: Any write (byte or nibble) makes `running` 0 on the next cycle and stops a count in progress. A tick in that cycle does not decrement.
- R5: A `start` pulse with no write and no wrap in the same cycle makes `running` 1 and `evt_flag` 0 on the next cycle. A `start` pulse in the same cycle as a write is ignored.
- R6: While `running` is 1, each cycle with the selected tick high lowers `count` by one on the next cycle. `rate_sel`=0 selects `tick_slow` and `rate_sel`=1 selects `tick_fast`. The unselected tick has no effect.
- R7: A selected tick while `running` is 1 and `count` is 0 gives, on the next cycle, `count`=FFh, `running`=0 and `evt_flag`=1. A `start` in that same cycle is ignored. While not running, `count` holds its value.
- R8: `irq_req` equals `evt_flag` AND `irq_en`, and `hold_rel` equals `evt_flag` AND `hold_en`. Both follow in the same cycle, with no register.
- R9: Once set, `evt_flag` stays 1 through writes and ticks until an accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_byte | input | 1 | Write the full byte from `wr_data` |
| wr_lo | input | 1 | Write the low nibble from `wr_data[3:0]` |
| wr_hi | input | 1 | Write the high nibble from `wr_data[7:4]` |
| wr_data | input | 8 | Write value |
| start | input | 1 | Arm strobe; starts counting and clears the flag |
| rate_sel | input | 1 | 0 = slow tick, 1 = fast tick |
| tick_slow | input | 1 | Single-cycle slow-rate enable |
| tick_fast | input | 1 | Single-cycle fast-rate enable |
| irq_en | input | 1 | Interrupt request enable |
| hold_en | input | 1 | Hold-release enable |
| count | output | 8 | Current counter value |
| running | output | 1 | Timer is armed and counting |
| evt_flag | output | 1 | Underflow event flag |
| irq_req | output | 1 | Interrupt request |
| hold_rel | output | 1 | Hold-release request |

## Verification
Writes, starts and ticks act on the clock edge that samples them. Their effect on `count`, `running` and `evt_flag` is therefore due exactly one cycle later, while `irq_req` and `hold_rel` follow the flag and enables within the same cycle.

The bench drives inputs shortly after each rising edge. A behavioural model updates at that edge from the previous inputs, and every output is compared with the model at the falling edge. Each registered result is therefore checked in the cycle it becomes due, and each combinational result is checked against the enables present at that moment.

Directed checks are placed at the falling edge after the capturing edge. They cover the reset values, the write and nibble cases, same-cycle write/start conflicts, and the wrap to all-ones.

// File: rtl/odt_pkg.sv
package odt_pkg;

    localparam int ODT_WIDTH = 8;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    // Decoded command for one cycle
    typedef struct packed {
        logic wr_any;
        logic start_ok;
        logic wrap;
        logic dec;
    } cnt_cmd_t;

    function automatic logic is_zero(input logic [ODT_WIDTH-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/odt_tick_sel.sv
module odt_tick_sel
    import odt_pkg::*;
(
    input  rate_e rate,
    input  logic  tick_slow,
    input  logic  tick_fast,
    output logic  tick
);
    always_comb begin
        unique case (rate)
            RATE_FAST: tick = tick_fast;
            default:   tick = tick_slow;
        endcase
    end
endmodule

// File: rtl/odt_load_ctrl.sv
module odt_load_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             wr_byte,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] cur,
    output logic             wr_any,
    output logic [WIDTH-1:0] wr_val
);
    localparam int HALF = WIDTH / 2;

    assign wr_any = wr_byte | wr_lo | wr_hi;

    always_comb begin
        wr_val = cur;
        if (wr_byte) begin
            wr_val = wr_data;
        end else begin
            if (wr_lo) wr_val[HALF-1:0]     = wr_data[HALF-1:0];
            if (wr_hi) wr_val[WIDTH-1:HALF] = wr_data[WIDTH-1:HALF];
        end
    end
endmodule

// File: rtl/odt_counter.sv
module odt_counter
    import odt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_any,
    input  logic [WIDTH-1:0] wr_val,
    input  logic             start,
    input  logic             tick,
    output logic [WIDTH-1:0] count,
    output logic             running,
    output cnt_cmd_t         cmd
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    always_comb begin
        cmd.wr_any   = wr_any;
        cmd.wrap     = !wr_any && running && tick && (count == '0);
        cmd.dec      = !wr_any && running && tick && (count != '0);
        cmd.start_ok = start && !wr_any && !cmd.wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
        end else if (cmd.wr_any) begin
            count   <= wr_val;
            running <= 1'b0;
        end else if (cmd.wrap) begin
            count   <= ALL_ONES;
            running <= 1'b0;
        end else begin
            if (cmd.dec)      count   <= count - 1'b1;
            if (cmd.start_ok) running <= 1'b1;
        end
    end
endmodule

// File: rtl/odt_flag.sv
module odt_flag
    import odt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_cmd_t cmd,
    input  logic     irq_en,
    input  logic     hold_en,
    output logic     evt_flag,
    output logic     irq_req,
    output logic     hold_rel
);
    always_ff @(posedge clk) begin
        if (rst)               evt_flag <= 1'b0;
        else if (cmd.wrap)     evt_flag <= 1'b1;
        else if (cmd.start_ok) evt_flag <= 1'b0;
    end

    assign irq_req  = evt_flag & irq_en;
    assign hold_rel = evt_flag & hold_en;
endmodule

// File: rtl/oneshot_dtimer.sv
module oneshot_dtimer
    import odt_pkg::*;
#(
    parameter int WIDTH = odt_pkg::ODT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_byte,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             start,
    input  logic             rate_sel,
    input  logic             tick_slow,
    input  logic             tick_fast,
    input  logic             irq_en,
    input  logic             hold_en,
    output logic [WIDTH-1:0] count,
    output logic             running,
    output logic             evt_flag,
    output logic             irq_req,
    output logic             hold_rel
);
    logic             tick;
    logic             wr_any;
    logic [WIDTH-1:0] wr_val;
    cnt_cmd_t         cmd;

    odt_tick_sel u_tick (
        .rate      (rate_e'(rate_sel)),
        .tick_slow (tick_slow),
        .tick_fast (tick_fast),
        .tick      (tick)
    );

    odt_load_ctrl #(.WIDTH(WIDTH)) u_load (
        .wr_byte (wr_byte),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .cur     (count),
        .wr_any  (wr_any),
        .wr_val  (wr_val)
    );

    odt_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .wr_any  (wr_any),
        .wr_val  (wr_val),
        .start   (start),
        .tick    (tick),
        .count   (count),
        .running (running),
        .cmd     (cmd)
    );

    odt_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .irq_en   (irq_en),
        .hold_en  (hold_en),
        .evt_flag (evt_flag),
        .irq_req  (irq_req),
        .hold_rel (hold_rel)
    );
endmodule

// File: rtl/odt_chk.sv
module odt_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_byte,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic             start,
    input logic             rate_sel,
    input logic             tick_slow,
    input logic             tick_fast,
    input logic             irq_en,
    input logic             hold_en,
    input logic [WIDTH-1:0] count,
    input logic             running,
    input logic             evt_flag,
    input logic             irq_req,
    input logic             hold_rel
);
    logic any_wr;
    logic sel_tick;

    assign any_wr   = wr_byte | wr_lo | wr_hi;
    assign sel_tick = rate_sel ? tick_fast : tick_slow;

    AST_WRITE_STOPS: assert property (@(posedge clk) disable iff (rst)
        any_wr |=> !running); // R4

    AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
        (start && !any_wr && !(running && sel_tick && count == '0)) |=> (running && !evt_flag)); // R5

    AST_WRAP_STOPS: assert property (@(posedge clk) disable iff (rst)
        (running && sel_tick && count == '0 && !any_wr) |=> (&count && !running && evt_flag)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!running && !any_wr) |=> $stable(count)); // R7

    AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!sel_tick && !any_wr) |=> $stable(count)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (evt_flag && !start) |=> evt_flag); // R9

    always_comb begin
        if (!rst) begin
            AST_REQ_GATING: assert ((irq_req == (evt_flag & irq_en)) && (hold_rel == (evt_flag & hold_en))); // R8
        end
    end
endmodule

bind oneshot_dtimer odt_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_byte   (wr_byte),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .start     (start),
    .rate_sel  (rate_sel),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .irq_en    (irq_en),
    .hold_en   (hold_en),
    .count     (count),
    .running   (running),
    .evt_flag  (evt_flag),
    .irq_req   (irq_req),
    .hold_rel  (hold_rel)
);

// File: tb/oneshot_dtimer_tb_top.sv
module oneshot_dtimer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_byte, wr_lo, wr_hi, start, rate_sel, tick_slow, tick_fast, irq_en, hold_en;
    logic [7:0] wr_data;
    logic [7:0] count;
    logic       running, evt_flag, irq_req, hold_rel;

    int n_checks = 0;
    int n_errors = 0;
    int m_cnt = 0;
    bit m_run = 0;
    bit m_evt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oneshot_dtimer dut_i (
        .clk(clk), .rst(rst), .wr_byte(wr_byte), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .start(start), .rate_sel(rate_sel), .tick_slow(tick_slow),
        .tick_fast(tick_fast), .irq_en(irq_en), .hold_en(hold_en), .count(count),
        .running(running), .evt_flag(evt_flag), .irq_req(irq_req), .hold_rel(hold_rel)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated from the inputs present at the edge
    always @(posedge clk) begin
        bit tk, wr, wrapped;
        tk = rate_sel ? tick_fast : tick_slow;
        wr = wr_byte | wr_lo | wr_hi;
        wrapped = 0;
        if (rst) begin
            m_cnt = 0; m_run = 0; m_evt = 0;
        end else if (wr) begin
            if (wr_byte) m_cnt = wr_data;
            else begin
                if (wr_lo) m_cnt = (m_cnt & 'hF0) | (wr_data & 'h0F);
                if (wr_hi) m_cnt = (m_cnt & 'h0F) | (wr_data & 'hF0);
            end
            m_run = 0;
        end else if (m_run && tk && m_cnt == 0) begin
            m_cnt = 255; m_run = 0; m_evt = 1; wrapped = 1;
        end else begin
            if (m_run && tk) m_cnt = m_cnt - 1;
            if (start) begin m_run = 1; m_evt = 0; end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R6", "count",    count,    m_cnt);
            chk("R4", "running",  running,  m_run);
            chk("R9", "evt_flag", evt_flag, m_evt);
            chk("R8", "irq_req",  irq_req,  m_evt & irq_en);
            chk("R8", "hold_rel", hold_rel, m_evt & hold_en);
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic idle();
        wr_byte = 0; wr_lo = 0; wr_hi = 0; start = 0; tick_slow = 0; tick_fast = 0;
    endtask

    task automatic settle();
        step(); idle(); @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst = 1; idle(); wr_data = 0; rate_sel = 0; irq_en = 0; hold_en = 0;
        repeat (3) step();
        @(negedge clk);
        chk("R1", "count in reset", count, 0);
        chk("R1", "running in reset", running, 0);
        chk("R1", "flag in reset", evt_flag, 0);
        step(); rst = 0;
        @(negedge clk);
        chk("R1", "count after reset", count, 0);

        // R2: byte write beats nibble writes
        step(); wr_byte = 1; wr_lo = 1; wr_hi = 1; wr_data = 8'h03; settle();
        chk("R2", "byte write", count, 8'h03);

        // R5: start arms; R6: slow ticks count, fast ignored
        step(); start = 1; settle();
        chk("R5", "armed", running, 1);
        step(); tick_fast = 1; settle();
        chk("R6", "unselected tick", count, 8'h03);
        step(); tick_slow = 1; settle();
        chk("R6", "one slow tick", count, 8'h02);
        repeat (2) begin step(); tick_slow = 1; step(); idle(); end
        @(negedge clk);
        chk("R6", "at zero", count, 8'h00);
        irq_en = 1; hold_en = 1;
        step(); tick_slow = 1; start = 1; settle();
        chk("R7", "wrap count", count, 8'hFF);
        chk("R7", "wrap stops", running, 0);
        chk("R7", "wrap flag", evt_flag, 1);
        chk("R8", "irq", irq_req, 1);
        step(); tick_slow = 1; settle();
        chk("R7", "idle hold", count, 8'hFF);

        // R3: nibble writes, flag persists (R9)
        step(); wr_lo = 1; wr_data = 8'hA5; settle();
        chk("R3", "low nibble", count, 8'hF5);
        step(); wr_hi = 1; wr_data = 8'h3C; settle();
        chk("R3", "high nibble", count, 8'h35);
        step(); wr_hi = 1; wr_lo = 1; wr_data = 8'h81; settle();
        chk("R3", "both nibbles", count, 8'h81);
        chk("R9", "flag kept", evt_flag, 1);

        // R5: write and start same cycle, start ignored
        step(); wr_byte = 1; start = 1; wr_data = 8'h10; settle();
        chk("R5", "start lost to write", running, 0);
        chk("R9", "flag not cleared", evt_flag, 1);

        // R4: write aborts a count, fast rate used
        rate_sel = 1;
        step(); start = 1; settle();
        chk("R5", "flag cleared", evt_flag, 0);
        step(); tick_fast = 1; settle();
        chk("R6", "fast tick", count, 8'h0F);
        step(); tick_fast = 1; wr_lo = 1; wr_data = 8'h07; settle();
        chk("R4", "write aborts", running, 0);
        chk("R4", "no decrement on write", count, 8'h07);

        // Random phase, compared every cycle by the model
        for (int i = 0; i < 4000; i++) begin
            step();
            idle();
            wr_data   = 8'($urandom);
            wr_byte   = ($urandom % 40) == 0;
            wr_lo     = ($urandom % 60) == 0;
            wr_hi     = ($urandom % 60) == 0;
            start     = ($urandom % 12) == 0;
            tick_slow = ($urandom % 3) == 0;
            tick_fast = ($urandom % 2) == 0;
            if (($urandom % 50) == 0) rate_sel = ~rate_sel;
            irq_en    = 1'($urandom);
            hold_en   = 1'($urandom);
        end
        settle();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule